// File: doc/BRIEF.md
# Accumulator-Steered Fractional-N Clock Divider

This block divides a fast input clock by an average ratio of N + k/M. A down-counter closes each output period with a single-cycle pulse after N or N+1 input cycles. A modulo-M phase accumulator is stepped once per output period, on that pulse. It adds k and wraps at M. When it wraps, the resulting carry makes the next period one input cycle longer. Over any M periods with a fixed setting, exactly k periods are long and M−k are short.

The accumulator residue is exposed as a phase-error word. Its scale is 2π/M radians per unit. Between wraps it rises by k per period, and it falls back by M−k when a wrap happens. The carry bit is exposed as the modulus-select output for the period it controls. The divider has no dithering and no noise shaping: the sequence of ratios is periodic and deterministic.

The setting inputs (N, k, M) are sampled only on the period-boundary edge. A change never truncates a period that is already running. A setting with k ≥ M is flagged on an error output.

Top module: `frac_div_top`

## Requirements
- R1: A clock edge with `rst` high clears `phase_err` and `mod_sel` to 0 and starts a divide-by-N period: `out_pulse` rises N−1 edges after the last reset edge.
- R2: On each boundary edge (a rising edge while `out_pulse` is 1), `phase_err` becomes `phase_err + k`, minus M when that sum is ≥ M. On any other edge it holds its value. While k < M, it stays below M.
- R3: On each boundary edge, `mod_sel` becomes 1 exactly when the sum `phase_err + k` is ≥ M, and 0 otherwise. It holds that value for the whole following period.
- R4: The period that begins at a boundary edge lasts N + `mod_sel` input cycles. The next `out_pulse` comes N + `mod_sel` edges after the previous one.
- R5: `out_pulse` is 1 for exactly one input cycle: the last cycle of each period.
- R6: With a constant setting, any M consecutive periods hold exactly k periods with `mod_sel` = 1.
- R7: `n_div`, `frac_k` and `frac_m` are used only on the boundary edge. Changing them in mid-period alters neither the length of the running period nor `phase_err`.
- R8: With k = 0, `mod_sel` never asserts, `phase_err` stays 0 and every period is N cycles.
- R9: `cfg_err` is updated on reset and on each boundary edge. It becomes 1 exactly when the sampled `frac_k` is ≥ the sampled `frac_m` (this includes M = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| n_div | input | 10 | Integer divide ratio N (4 or more) |
| frac_k | input | 12 | Fractional numerator k |
| frac_m | input | 12 | Accumulator modulus M (1 to 4095) |
| out_pulse | output | 1 | Divided output, one input cycle wide per period |
| mod_sel | output | 1 | Carry of the last accumulation; 1 means the current period is N+1 |
| phase_err | output | 12 | Accumulator residue, phase error in units of 2π/M |
| cfg_err | output | 1 | Sampled setting has k ≥ M |

## Verification
`phase_err`, `mod_sel` and `cfg_err` change only on the boundary edge. The bench therefore reads them at the falling edge just after the pulse, which is one edge after the boundary. The next pulse is due N + `mod_sel` falling edges after the previous one. Each scenario counts falling edges from pulse to pulse and compares that gap with the value its own model predicts. After reset, the first pulse is counted from the falling edge where `rst` drops and is expected N−1 edges later. All inputs are changed at falling edges, either while the pulse is high (so the boundary edge takes them) or in mid-period (to show that they are ignored).

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int DEF_INT_W  = 10;
    localparam int DEF_FRAC_W = 12;

    // Ratio chosen for the coming output period
    typedef enum logic {
        RATIO_BASE = 1'b0,   // divide by N
        RATIO_EXT  = 1'b1    // divide by N+1
    } ratio_e;
endpackage

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              period_end,
    input  logic [FRAC_W-1:0] frac_k,
    input  logic [FRAC_W-1:0] frac_m,
    output ratio_e            ratio_nxt,
    output logic              mod_sel,
    output logic [FRAC_W-1:0] phase_err,
    output logic              cfg_err
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        ratio_e            sel;
        logic              err;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [FRAC_W:0] sum_d;
    logic            wrap_d;

    always_comb begin
        sum_d     = {1'b0, st_q.acc} + {1'b0, frac_k};
        wrap_d    = (sum_d >= {1'b0, frac_m});
        ratio_nxt = wrap_d ? RATIO_EXT : RATIO_BASE;
        st_d      = st_q;
        if (rst) begin
            st_d.acc = '0;
            st_d.sel = RATIO_BASE;
            st_d.err = (frac_k >= frac_m);
        end else if (period_end) begin
            st_d.acc = FRAC_W'(wrap_d ? (sum_d - {1'b0, frac_m}) : sum_d);
            st_d.sel = ratio_nxt;
            st_d.err = (frac_k >= frac_m);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_err = st_q.acc;
    assign mod_sel   = (st_q.sel == RATIO_EXT);
    assign cfg_err   = st_q.err;

    // R2
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(st_q.acc));

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(st_q.sel));

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (period_end && frac_k < frac_m && st_q.acc < frac_m)
        |=> (st_q.acc < $past(frac_m)));

    // R8
    zero_k_no_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (period_end && frac_k == '0 && st_q.acc < frac_m)
        |=> (st_q.sel == RATIO_BASE));
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
    import fdiv_pkg::*;
#(
    parameter int INT_W = DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] n_div,
    input  ratio_e           ratio_nxt,
    output logic             period_end
);
    typedef struct packed {
        logic [INT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = n_div - 1'b1;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = (ratio_nxt == RATIO_EXT) ? n_div : (n_div - 1'b1);
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign period_end = (st_q.cnt == '0);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);
endmodule

// File: rtl/frac_div_top.sv
module frac_div_top
    import fdiv_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  n_div,
    input  logic [FRAC_W-1:0] frac_k,
    input  logic [FRAC_W-1:0] frac_m,
    output logic              out_pulse,
    output logic              mod_sel,
    output logic [FRAC_W-1:0] phase_err,
    output logic              cfg_err
);
    ratio_e ratio_nxt;
    logic   period_end;

    fdiv_counter #(.INT_W(INT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .n_div      (n_div),
        .ratio_nxt  (ratio_nxt),
        .period_end (period_end)
    );

    fdiv_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .frac_k     (frac_k),
        .frac_m     (frac_m),
        .ratio_nxt  (ratio_nxt),
        .mod_sel    (mod_sel),
        .phase_err  (phase_err),
        .cfg_err    (cfg_err)
    );

    assign out_pulse = period_end;

    // R4
    sel_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (out_pulse && mod_sel) |=> !out_pulse);
endmodule

// File: tb/tb_frac_div_top.sv
module tb_frac_div_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  n_div = 10'd5;
    logic [11:0] frac_k = 12'd0;
    logic [11:0] frac_m = 12'd1;
    logic        out_pulse, mod_sel, cfg_err;
    logic [11:0] phase_err;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    int acc_m = 0;

    frac_div_top dut (
        .clk(clk), .rst(rst), .n_div(n_div), .frac_k(frac_k), .frac_m(frac_m),
        .out_pulse(out_pulse), .mod_sel(mod_sel), .phase_err(phase_err), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Counts falling edges until out_pulse is seen; gap already holds edges taken
    task automatic wait_pulse(inout int gap);
        while (!out_pulse && gap < 5000) begin
            @(negedge clk);
            gap++;
        end
    endtask

    task automatic do_reset(input int n, input int k, input int m);
        int gap;
        n_div = 10'(n); frac_k = 12'(k); frac_m = 12'(m);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(phase_err == 0, "R1 phase_err after reset", phase_err, 0);
        check(mod_sel == 0, "R1 mod_sel after reset", mod_sel, 0);
        check(out_pulse == 0, "R1 out_pulse after reset", out_pulse, 0);
        check(cfg_err == (k >= m), "R9 cfg_err after reset", cfg_err, int'(k >= m));
        rst = 1'b0;
        gap = 0;
        wait_pulse(gap);
        check(gap == n - 1, "R1 first pulse distance", gap, n - 1);
        acc_m = 0;
    endtask

    // Called at a falling edge with out_pulse high; the coming edge is a boundary
    task automatic one_period(input int n, input int k, input int m, input int alt_n,
                              input string tag, output int carry);
        int gap;
        int sum;
        n_div = 10'(n); frac_k = 12'(k); frac_m = 12'(m);
        carry = 0;
        if (k < m) begin
            sum = acc_m + k;
            carry = (sum >= m) ? 1 : 0;
            acc_m = carry ? sum - m : sum;
        end
        @(negedge clk);
        gap = 1;
        check(cfg_err == (k >= m), {"R9 cfg_err ", tag}, cfg_err, int'(k >= m));
        if (k < m) begin
            check(phase_err == acc_m, {"R2 phase_err ", tag}, phase_err, acc_m);
            check(mod_sel == carry, {"R3 mod_sel ", tag}, mod_sel, carry);
            check(out_pulse == 0, {"R5 pulse width ", tag}, out_pulse, 0);
            if (alt_n != 0) begin
                n_div = 10'(alt_n); frac_k = 12'(m - 1); frac_m = 12'(m + 7);
            end
            wait_pulse(gap);
            check(gap == n + carry, {"R4 period length ", tag}, gap, n + carry);
            if (alt_n != 0)
                check(phase_err == acc_m, {"R7 phase_err after mid change ", tag},
                      phase_err, acc_m);
        end else begin
            wait_pulse(gap);
        end
    endtask

    task automatic test_integer();
        int c;
        do_reset(5, 0, 7);
        for (int i = 0; i < 10; i++) begin
            one_period(5, 0, 7, 0, "R8 integer mode", c);
            check(c == 0 && mod_sel == 0, "R8 no carry with k=0", mod_sel, 0);
        end
    endtask

    task automatic test_fraction();
        int c;
        int ones;
        do_reset(4, 3, 8);
        for (int w = 0; w < 2; w++) begin
            ones = 0;
            for (int i = 0; i < 8; i++) begin
                one_period(4, 3, 8, 0, "k=3 M=8", c);
                ones += c;
            end
            check(ones == 3, "R6 carries per 8 periods", ones, 3);
        end
    endtask

    task automatic test_wide_modulus();
        int c;
        int ones = 0;
        do_reset(10, 4094, 4095);
        for (int i = 0; i < 4095; i++) begin
            one_period(10, 4094, 4095, 0, "k=4094 M=4095", c);
            ones += c;
        end
        check(ones == 4094, "R6 carries over 4095 periods", ones, 4094);
    endtask

    task automatic test_unit_modulus();
        int c;
        do_reset(7, 0, 1);
        for (int i = 0; i < 4; i++)
            one_period(7, 0, 1, 0, "R8 M=1", c);
    endtask

    task automatic test_mid_change();
        int c;
        do_reset(6, 1, 3);
        for (int i = 0; i < 6; i++)
            one_period(6, 1, 3, 9, "R7 mid-period change", c);
        // new setting taken at the boundary
        for (int i = 0; i < 5; i++)
            one_period(12, 2, 5, 0, "R7 new setting at boundary", c);
    endtask

    task automatic test_cfg_error();
        int c;
        do_reset(5, 1, 4);
        one_period(5, 1, 4, 0, "valid before error", c);
        one_period(5, 6, 6, 0, "R9 k equal M", c);
        check(cfg_err == 1, "R9 flag held to next boundary", cfg_err, 1);
        do_reset(5, 9, 3);
        do_reset(5, 2, 9);
        one_period(5, 2, 9, 0, "R9 flag cleared", c);
    endtask

    initial begin
        test_integer();
        test_fraction();
        test_wide_modulus();
        test_unit_modulus();
        test_mid_change();
        test_cfg_error();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule